// File: doc/BRIEF.md
# Paged Virtual Address Translator

This block turns an 11-bit virtual word address from the processor into a 10-bit word address inside a 1024-word user region. The upper six address bits name one of 64 virtual pages. The lower five bits are the word offset inside a 32-word page. User memory is cut into 32 frames of 32 words. The table holds one entry per physical frame, so it is an inverted table. A lookup compares the virtual page number against the page field of every valid entry at the same time. The index of the matching entry becomes the frame number, the upper five bits of the physical address.

Translation is combinational. A miss raises an invalid-address fault and asks the processor to rewind its program counter to the faulting instruction. On each hit the entry records the current time as its last-access time, and a write access also records it as its last-modify time. Supervisor software loads and inspects the table through an indexed register port. When virtual memory is switched off, the address goes straight through as a user-space address.

Top module: `vm_xlate`

## Requirements
- R1: With `vm_en_i`=1 and `req_i`=1, the virtual page is `va_i[10:5]`. If entry i is valid and its page field equals that page, `hit_o`=1 and `pa_o` = {i[4:0], `va_i[4:0]`}.
- R2: With `vm_en_i`=1 and `req_i`=1, if no valid entry matches (an invalid entry never matches), then `fault_o`=1, `pc_rewind_o`=1, `hit_o`=0 and `pa_o`=0.
- R3: On every hit, `pa_o[4:0]` equals `va_i[4:0]`.
- R4: `hit_o` and `fault_o` are never both high. With `req_i`=0, both are low and so is `pc_rewind_o`.
- R5: When several valid entries hold the same page number, the entry with the lowest index supplies the frame.
- R6: At the clock edge of a hitting access, `now_i` is stored in that entry's access time. A faulting access stores nothing.
- R7: A hitting access with `we_i`=1 also stores `now_i` in the entry's modify time. With `we_i`=0 the modify time is left unchanged.
- R8: With `vm_en_i`=0 there is no translation. If `va_i[10]`=0, then `hit_o`=1 and `pa_o`=`va_i[9:0]`. If `va_i[10]`=1, the access faults as in R2. No time field is updated.
- R9: Register port field codes, selected on `cfg_field_i`:
  - 0 = control: bit 6 is valid, bits 5:0 are the page number.
  - 1 = access time.
  - 2 = modify time.
  - 3 = reserved: writes are ignored and reads return 0.

  `cfg_rdata_o` shows the field selected by `cfg_idx_i` and `cfg_field_i` combinationally. Writes take effect at the clock edge where `cfg_we_i`=1.
- R10: After reset every entry is invalid and all its fields read 0.
- R11: If a software write and a hardware time update target the same field of the same entry in one cycle, the software value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access strobe |
| we_i | input | 1 | Access is a write |
| vm_en_i | input | 1 | Virtual memory enable |
| va_i | input | 11 | Virtual word address |
| now_i | input | 16 | Current time value |
| pa_o | output | 10 | User-space word address |
| hit_o | output | 1 | Translation succeeded |
| fault_o | output | 1 | Invalid-address fault |
| pc_rewind_o | output | 1 | Reset program counter to faulting instruction |
| cfg_we_i | input | 1 | Table register write strobe |
| cfg_idx_i | input | 5 | Table entry index |
| cfg_field_i | input | 2 | Field code |
| cfg_wdata_i | input | 16 | Write data |
| cfg_rdata_o | output | 16 | Read data |

## Verification
The hardest situation to reach from the ports is a single cycle in which a hitting write access stamps an entry while software writes that same entry's access-time field. The bench drives one cycle that combines a translated write to entry 7 with a register write of a marker value to field 1 of entry 7. It then reads back both time fields: the access time must hold the marker and the modify time must hold the time value. Duplicate page numbers are set up in entries 12 and 20 to force the priority rule. Entry 12 is then invalidated to show that entry 20 takes over.

// File: rtl/vm_xlate_pkg.sv
package vm_xlate_pkg;
  typedef enum logic [1:0] {
    FLD_CTRL = 2'd0,
    FLD_ACC  = 2'd1,
    FLD_MOD  = 2'd2,
    FLD_RSVD = 2'd3
  } pt_field_e;
endpackage

// File: rtl/vm_pt_store.sv
module vm_pt_store
  import vm_xlate_pkg::*;
#(
  parameter int N     = 32,
  parameter int VPN_W = 6,
  parameter int TS_W  = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cfg_we_i,
  input  logic [IDX_W-1:0]           cfg_idx_i,
  input  pt_field_e                  cfg_field_i,
  input  logic [TS_W-1:0]            cfg_wdata_i,
  input  logic                       stamp_en_i,
  input  logic                       stamp_mod_i,
  input  logic [IDX_W-1:0]           stamp_idx_i,
  input  logic [TS_W-1:0]            now_i,
  output logic [N-1:0]               valid_o,
  output logic [N-1:0][VPN_W-1:0]    vpn_o,
  output logic [N-1:0][TS_W-1:0]     acc_o,
  output logic [N-1:0][TS_W-1:0]     mod_o,
  output logic [TS_W-1:0]            rdata_o
);

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic sel_cfg, sel_stamp;
    assign sel_cfg   = cfg_we_i   && (cfg_idx_i   == IDX_W'(g));
    assign sel_stamp = stamp_en_i && (stamp_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[g] <= 1'b0;
        vpn_o[g]   <= '0;
      end else if (sel_cfg && cfg_field_i == FLD_CTRL) begin
        valid_o[g] <= cfg_wdata_i[VPN_W];
        vpn_o[g]   <= cfg_wdata_i[VPN_W-1:0];
      end
    end

    // software write beats hardware stamp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               acc_o[g] <= '0;
      else if (sel_cfg && cfg_field_i == FLD_ACC) acc_o[g] <= cfg_wdata_i;
      else if (sel_stamp)                         acc_o[g] <= now_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mod_o[g] <= '0;
      else if (sel_cfg && cfg_field_i == FLD_MOD) mod_o[g] <= cfg_wdata_i;
      else if (sel_stamp && stamp_mod_i)          mod_o[g] <= now_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (cfg_field_i)
      FLD_CTRL: rdata_o = TS_W'({valid_o[cfg_idx_i], vpn_o[cfg_idx_i]});
      FLD_ACC:  rdata_o = acc_o[cfg_idx_i];
      FLD_MOD:  rdata_o = mod_o[cfg_idx_i];
      default:  rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/vm_match.sv
module vm_match #(
  parameter int N     = 32,
  parameter int VPN_W = 6,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]            valid_i,
  input  logic [N-1:0][VPN_W-1:0] vpn_tbl_i,
  input  logic [VPN_W-1:0]        vpn_i,
  output logic                    found_o,
  output logic [IDX_W-1:0]        idx_o
);

  logic [N-1:0] hit_vec;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = valid_i[g] && (vpn_tbl_i[g] == vpn_i);
  end

  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (hit_vec[k]) idx_o = IDX_W'(k);
    end
  end

  assign found_o = |hit_vec;

endmodule

// File: rtl/vm_xlate.sv
module vm_xlate
  import vm_xlate_pkg::*;
#(
  parameter int VA_W      = 11,
  parameter int OFS_W     = 5,
  parameter int FRAME_CNT = 32,
  parameter int TS_W      = 16,
  localparam int VPN_W    = VA_W - OFS_W,
  localparam int IDX_W    = $clog2(FRAME_CNT),
  localparam int PA_W     = IDX_W + OFS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             vm_en_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic [TS_W-1:0]  now_i,
  output logic [PA_W-1:0]  pa_o,
  output logic             hit_o,
  output logic             fault_o,
  output logic             pc_rewind_o,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic [1:0]       cfg_field_i,
  input  logic [TS_W-1:0]  cfg_wdata_i,
  output logic [TS_W-1:0]  cfg_rdata_o
);

  logic [FRAME_CNT-1:0]            valid_q;
  logic [FRAME_CNT-1:0][VPN_W-1:0] vpn_q;
  logic [FRAME_CNT-1:0][TS_W-1:0]  acc_ts;
  logic [FRAME_CNT-1:0][TS_W-1:0]  mod_ts;
  logic                            found;
  logic [IDX_W-1:0]                frame;
  logic                            direct_ok;
  logic                            stamp_en;

  vm_pt_store #(.N(FRAME_CNT), .VPN_W(VPN_W), .TS_W(TS_W), .IDX_W(IDX_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_idx_i   (cfg_idx_i),
    .cfg_field_i (pt_field_e'(cfg_field_i)),
    .cfg_wdata_i (cfg_wdata_i),
    .stamp_en_i  (stamp_en),
    .stamp_mod_i (we_i),
    .stamp_idx_i (frame),
    .now_i       (now_i),
    .valid_o     (valid_q),
    .vpn_o       (vpn_q),
    .acc_o       (acc_ts),
    .mod_o       (mod_ts),
    .rdata_o     (cfg_rdata_o)
  );

  vm_match #(.N(FRAME_CNT), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_match (
    .valid_i   (valid_q),
    .vpn_tbl_i (vpn_q),
    .vpn_i     (va_i[VA_W-1:OFS_W]),
    .found_o   (found),
    .idx_o     (frame)
  );

  // untranslated access must land inside user space
  assign direct_ok = (va_i >> PA_W) == '0;
  assign stamp_en  = req_i && vm_en_i && found;

  always_comb begin
    pa_o    = '0;
    hit_o   = 1'b0;
    fault_o = 1'b0;
    if (req_i) begin
      if (vm_en_i) begin
        if (found) begin
          hit_o = 1'b1;
          pa_o  = {frame, va_i[OFS_W-1:0]};
        end else begin
          fault_o = 1'b1;
        end
      end else if (direct_ok) begin
        hit_o = 1'b1;
        pa_o  = va_i[PA_W-1:0];
      end else begin
        fault_o = 1'b1;
      end
    end
  end

  assign pc_rewind_o = fault_o;

endmodule

// File: rtl/vm_xlate_chk.sv
module vm_xlate_chk #(
  parameter int VA_W      = 11,
  parameter int OFS_W     = 5,
  parameter int FRAME_CNT = 32,
  parameter int TS_W      = 16,
  parameter int PA_W      = 10
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           req_i,
  input logic                           we_i,
  input logic                           vm_en_i,
  input logic                           cfg_we_i,
  input logic [VA_W-1:0]                va_i,
  input logic [TS_W-1:0]                now_i,
  input logic [PA_W-1:0]                pa_o,
  input logic                           hit_o,
  input logic                           fault_o,
  input logic                           pc_rewind_o,
  input logic [FRAME_CNT-1:0][TS_W-1:0] acc_ts_i,
  input logic [FRAME_CNT-1:0][TS_W-1:0] mod_ts_i
);

  AST_HIT_FAULT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && fault_o)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> !hit_o && !fault_o && !pc_rewind_o); // R4
  AST_REWIND_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_rewind_o |-> req_i && !hit_o && pa_o == '0); // R2
  AST_OFFSET_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> pa_o[OFS_W-1:0] == va_i[OFS_W-1:0]); // R3
  AST_DIRECT_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !vm_en_i && (va_i >> PA_W) == '0) |-> hit_o && pa_o == va_i[PA_W-1:0]); // R8
  AST_DIRECT_NO_STAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !vm_en_i && !cfg_we_i) |=> $stable(acc_ts_i) && $stable(mod_ts_i)); // R8
  AST_ACC_STAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && vm_en_i && hit_o && !cfg_we_i) |=>
      acc_ts_i[$past(pa_o[PA_W-1:OFS_W])] == $past(now_i)); // R6
  AST_MOD_STAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && vm_en_i && hit_o && we_i && !cfg_we_i) |=>
      mod_ts_i[$past(pa_o[PA_W-1:OFS_W])] == $past(now_i)); // R7
  AST_READ_KEEPS_MOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && vm_en_i && hit_o && !we_i && !cfg_we_i) |=> $stable(mod_ts_i)); // R7
  AST_FAULT_NO_STAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !cfg_we_i) |=> $stable(acc_ts_i)); // R6

endmodule

bind vm_xlate vm_xlate_chk #(
  .VA_W(VA_W), .OFS_W(OFS_W), .FRAME_CNT(FRAME_CNT), .TS_W(TS_W), .PA_W(PA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .vm_en_i     (vm_en_i),
  .cfg_we_i    (cfg_we_i),
  .va_i        (va_i),
  .now_i       (now_i),
  .pa_o        (pa_o),
  .hit_o       (hit_o),
  .fault_o     (fault_o),
  .pc_rewind_o (pc_rewind_o),
  .acc_ts_i    (acc_ts),
  .mod_ts_i    (mod_ts)
);

// File: tb/vm_xlate_test.sv
module vm_xlate_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, vm = 1'b0;
  logic [10:0] va = '0;
  logic [15:0] now = '0;
  logic [9:0]  pa;
  logic        hit, fault, rew;
  logic        cwe = 1'b0;
  logic [4:0]  cidx = '0;
  logic [1:0]  cfld = '0;
  logic [15:0] cwd = '0, crd;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_rd;
    logic        hit, fault;
    logic [9:0]  pa;
    logic [15:0] rdata;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vm_xlate uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .vm_en_i(vm),
    .va_i(va), .now_i(now), .pa_o(pa), .hit_o(hit), .fault_o(fault),
    .pc_rewind_o(rew), .cfg_we_i(cwe), .cfg_idx_i(cidx), .cfg_field_i(cfld),
    .cfg_wdata_i(cwd), .cfg_rdata_o(crd)
  );

  function automatic logic [10:0] mkva(input logic [5:0] p, input logic [4:0] o);
    return {p, o};
  endfunction

  task automatic drive(input logic r, w, v, input logic [10:0] a, input logic [15:0] t,
                       input logic ce, input logic [4:0] ci, input logic [1:0] cf,
                       input logic [15:0] cd);
    @(negedge clk);
    req = r; we = w; vm = v; va = a; now = t;
    cwe = ce; cidx = ci; cfld = cf; cwd = cd;
  endtask

  task automatic push_xl(input logic h, f, input logic [9:0] p, input string tag);
    exp_t e;
    e.is_rd = 1'b0; e.hit = h; e.fault = f; e.pa = p; e.rdata = '0; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic acc(input logic r, w, v, input logic [10:0] a, input logic [15:0] t,
                     input logic h, f, input logic [9:0] p, input string tag);
    drive(r, w, v, a, t, 1'b0, '0, '0, '0);
    push_xl(h, f, p, tag);
  endtask

  task automatic cfg_wr(input logic [4:0] i, input logic [1:0] f, input logic [15:0] d);
    drive(1'b0, 1'b0, 1'b1, '0, '0, 1'b1, i, f, d);
  endtask

  task automatic rd(input logic [4:0] i, input logic [1:0] f, input logic [15:0] d,
                    input string tag);
    exp_t e;
    drive(1'b0, 1'b0, 1'b1, '0, '0, 1'b0, i, f, '0);
    e.is_rd = 1'b1; e.hit = 1'b0; e.fault = 1'b0; e.pa = '0; e.rdata = d; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compares mid low phase of the cycle the item was driven in
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_chk++;
        if (e.is_rd) begin
          if (crd !== e.rdata) begin
            n_fail++;
            $display("FAIL %s rdata act=%h exp=%h", e.tag, crd, e.rdata);
          end
        end else if (hit !== e.hit || fault !== e.fault || rew !== e.fault || pa !== e.pa) begin
          n_fail++;
          $display("FAIL %s act hit=%b fault=%b rew=%b pa=%h exp hit=%b fault=%b rew=%b pa=%h",
                   e.tag, hit, fault, rew, pa, e.hit, e.fault, e.fault, e.pa);
        end
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    rd(5'd0, 2'd0, 16'h0000, "R10");
    rd(5'd31, 2'd1, 16'h0000, "R10");
    rd(5'd31, 2'd2, 16'h0000, "R10");
    acc(1, 0, 1, mkva(6'h00, 5'd0), 16'h0001, 0, 1, 10'h000, "R2");
    // table setup (R9 control format: bit6 valid, bits5:0 page)
    cfg_wr(5'd3, 2'd0, 16'h0055);
    cfg_wr(5'd7, 2'd0, 16'h006A);
    cfg_wr(5'd9, 2'd0, 16'h003F);
    cfg_wr(5'd12, 2'd0, 16'h0045);
    cfg_wr(5'd20, 2'd0, 16'h0045);
    rd(5'd3, 2'd0, 16'h0055, "R9");
    // R1 basic hit, R6 access stamp
    acc(1, 0, 1, mkva(6'h15, 5'd17), 16'h1111, 1, 0, {5'd3, 5'd17}, "R1");
    rd(5'd3, 2'd1, 16'h1111, "R6");
    rd(5'd3, 2'd2, 16'h0000, "R7");
    // R3 / R7 write access
    acc(1, 1, 1, mkva(6'h2A, 5'd31), 16'h2222, 1, 0, {5'd7, 5'd31}, "R3");
    rd(5'd7, 2'd1, 16'h2222, "R7");
    rd(5'd7, 2'd2, 16'h2222, "R7");
    // R2 invalid entry never matches; R6 fault stamps nothing
    acc(1, 0, 1, mkva(6'h3F, 5'd4), 16'h4444, 0, 1, 10'h000, "R2");
    rd(5'd9, 2'd1, 16'h0000, "R6");
    // R5 duplicate page numbers
    acc(1, 0, 1, mkva(6'h05, 5'd9), 16'h5555, 1, 0, {5'd12, 5'd9}, "R5");
    rd(5'd20, 2'd1, 16'h0000, "R5");
    cfg_wr(5'd12, 2'd0, 16'h0005);
    acc(1, 0, 1, mkva(6'h05, 5'd9), 16'h5556, 1, 0, {5'd20, 5'd9}, "R5");
    // R4 idle strobe
    acc(0, 0, 1, mkva(6'h15, 5'd1), 16'h0000, 0, 0, 10'h000, "R4");
    // R8 direct mode
    acc(1, 1, 0, 11'h2AB, 16'h6666, 1, 0, 10'h2AB, "R8");
    rd(5'd3, 2'd1, 16'h1111, "R8");
    rd(5'd3, 2'd2, 16'h0000, "R8");
    acc(1, 0, 0, 11'h4AB, 16'h6667, 0, 1, 10'h000, "R8");
    // R9 reserved field
    cfg_wr(5'd3, 2'd3, 16'hFFFF);
    rd(5'd3, 2'd3, 16'h0000, "R9");
    rd(5'd3, 2'd0, 16'h0055, "R9");
    rd(5'd3, 2'd1, 16'h1111, "R9");
    // R11 software write and stamp collide on entry 7 access time
    drive(1, 1, 1, mkva(6'h2A, 5'd2), 16'h3333, 1'b1, 5'd7, 2'd1, 16'hBEEF);
    push_xl(1, 0, {5'd7, 5'd2}, "R11");
    rd(5'd7, 2'd1, 16'hBEEF, "R11");
    rd(5'd7, 2'd2, 16'h3333, "R11");
    drive(0, 0, 0, '0, '0, 1'b0, '0, '0, '0);
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule